// File: doc/BRIEF.md
# Indexed Configuration RAM Port with NMI Mask

This block places a small non-volatile configuration memory behind two byte-wide I/O addresses. A write to the index port latches which of 128 locations the next data-port access reaches. The most significant bit of that same byte is captured as a mask flag for the non-maskable interrupt line. Software therefore disables NMI when it selects a location. It enables NMI again by selecting a harmless location with that bit clear.

A write to the data port stores a byte in the selected location. A read strobe on the data port returns the stored byte one cycle later. Location 0Dh is a fixed, read-only status byte, so a data write that lands there after an interrupted access sequence changes nothing. Location 0Ah reports an update-in-progress flag in its top bit. A pulse on the update request input raises that flag for a programmable number of cycles. When the window closes, the time-base location 0 advances by one, which models the clock registers changing after the flag warns software.

The bus is a plain strobe interface with no back-pressure. Every access completes in the cycle it is strobed, and reads deliver one beat marked by a one-cycle valid pulse that cannot be stalled.

Top module: `cmos_port`

## Requirements
- R1: A write to I/O address 70h latches bits 6:0 of the byte as the location index, and every later data-port access at address 71h uses the most recently latched index.
- R2: `nmi_disable` equals bit 7 of the most recent index-port write (1 = NMI disabled) and changes only on an index-port write.
- R3: Reset sets the index to 0, `nmi_disable` to 0 and the update flag to 0, and it leaves the stored bytes unchanged.
- R4: A read strobe on the data port gives `io_rvalid` high for one cycle after the strobe edge, with the selected byte on `io_rdata`.
- R5: A data-port write stores the byte in the selected location on the clock edge where the write strobe is high.
- R6: Location 0Dh always reads 80h, and a data-port write while 0Dh is selected changes no stored byte.
- R7: A read of location 0Ah returns the update flag in bit 7 and stored bits 6:0, and bit 7 of a write to 0Ah is discarded.
- R8: An `upd_req` pulse with no window running holds `uip` high for exactly UIP_CYCLES cycles, and a pulse during a running window is ignored.
- R9: `upd_commit` is high in the last cycle of the window, and on that edge location 0 increments by one, modulo 256.
- R10: A data-port write to location 0 on the same edge as the update commit takes precedence over the increment.
- R11: Strobes at any I/O address other than 70h and 71h change neither the index, the NMI mask nor any stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O address of the access |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| upd_req | input | 1 | Request to start an update window |
| io_rdata | output | 8 | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | One-cycle read-data valid |
| nmi_disable | output | 1 | NMI mask to the interrupt logic, 1 = masked |
| uip | output | 1 | Update in progress |
| upd_commit | output | 1 | Last cycle of the update window |

## Verification
The update commit and a bus write to location 0 can land on the same clock edge, and both want to change the same byte. The bench starts a window and counts its length in cycles. It then places a data-port write to location 0 exactly on the edge where `upd_commit` is high. It confirms the commit cycle at the ports and then reads the location back, expecting the bus value and not the incremented one. A second window with no competing write checks that the increment alone appears.

// File: rtl/cmos_pkg.sv
package cmos_pkg;
  localparam int BYTE_W   = 8;
  localparam int STAT_A   = 'h0A;
  localparam int STAT_D   = 'h0D;
  localparam int TICK_LOC = 0;
  localparam logic [BYTE_W-1:0] STAT_D_VALUE = 8'h80;
endpackage

// File: rtl/cmos_index_reg.sv
module cmos_index_reg #(
  parameter int IDX_W = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [cmos_pkg::BYTE_W-1:0] wdata,
  output logic [IDX_W-1:0]            idx,
  output logic                        nmi_disable
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx         <= '0;
      nmi_disable <= 1'b0;
    end else if (wr) begin
      idx         <= wdata[IDX_W-1:0];
      nmi_disable <= wdata[cmos_pkg::BYTE_W-1];
    end
  end

  // R2
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(nmi_disable));

  // R2
  nmi_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> nmi_disable == $past(wdata[cmos_pkg::BYTE_W-1]));
endmodule

// File: rtl/cmos_update_timer.sv
module cmos_update_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic uip,
  output logic commit
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
    else if (req)
      cnt <= CNT_W'(CYCLES);
  end

  assign uip    = (cnt != '0);
  assign commit = (cnt == CNT_W'(1));

  // R8
  uip_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !uip) |=> uip);

  // R8
  uip_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uip && !commit) |=> uip);

  // R9
  uip_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !uip);
endmodule

// File: rtl/cmos_ram_array.sv
module cmos_ram_array #(
  parameter int IDX_W = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            idx,
  input  logic                        wr,
  input  logic                        rd,
  input  logic [cmos_pkg::BYTE_W-1:0] wdata,
  input  logic                        uip,
  input  logic                        commit,
  output logic [cmos_pkg::BYTE_W-1:0] rdata,
  output logic                        rvalid
);
  import cmos_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic              wr_ok;
  logic              tick_hit;

  assign wr_ok    = wr && (idx != IDX_W'(STAT_D));
  assign tick_hit = wr && (idx == IDX_W'(TICK_LOC));

  // storage has no reset: contents survive it
  always_ff @(posedge clk) begin
    if (commit && !tick_hit)
      mem[TICK_LOC] <= mem[TICK_LOC] + 1'b1;
    if (wr_ok)
      mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      if (rd) begin
        if (idx == IDX_W'(STAT_D))
          rdata <= STAT_D_VALUE;
        else if (idx == IDX_W'(STAT_A))
          rdata <= {uip, mem[STAT_A][BYTE_W-2:0]};
        else
          rdata <= mem[idx];
      end
    end
  end

  // R4
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid);

  // R10
  tick_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && tick_hit) |=> mem[TICK_LOC] == $past(wdata));
endmodule

// File: rtl/cmos_port.sv
module cmos_port #(
  parameter int          IDX_W      = 7,
  parameter logic [7:0]  INDEX_PORT = 8'h70,
  parameter logic [7:0]  DATA_PORT  = 8'h71,
  parameter int          UIP_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] io_addr,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic [7:0] io_wdata,
  input  logic       upd_req,
  output logic [7:0] io_rdata,
  output logic       io_rvalid,
  output logic       nmi_disable,
  output logic       uip,
  output logic       upd_commit
);
  logic             idx_wr;
  logic             dat_wr;
  logic             dat_rd;
  logic [IDX_W-1:0] idx;

  assign idx_wr = io_wr && (io_addr == INDEX_PORT);
  assign dat_wr = io_wr && (io_addr == DATA_PORT);
  assign dat_rd = io_rd && (io_addr == DATA_PORT);

  cmos_index_reg #(.IDX_W(IDX_W)) u_index (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (idx_wr),
    .wdata       (io_wdata),
    .idx         (idx),
    .nmi_disable (nmi_disable)
  );

  cmos_update_timer #(.CYCLES(UIP_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (upd_req),
    .uip    (uip),
    .commit (upd_commit)
  );

  cmos_ram_array #(.IDX_W(IDX_W)) u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx    (idx),
    .wr     (dat_wr),
    .rd     (dat_rd),
    .wdata  (io_wdata),
    .uip    (uip),
    .commit (upd_commit),
    .rdata  (io_rdata),
    .rvalid (io_rvalid)
  );

  // R11
  stray_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr != INDEX_PORT) |=> $stable(nmi_disable));
endmodule

// File: tb/test_cmos_port.sv
module test_cmos_port;
  localparam int UIPN = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic       upd_req = 1'b0;
  logic [7:0] io_rdata;
  logic       io_rvalid;
  logic       nmi_disable;
  logic       uip;
  logic       upd_commit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmos_port #(.UIP_CYCLES(UIPN)) i_cmos_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .upd_req(upd_req), .io_rdata(io_rdata),
    .io_rvalid(io_rvalid), .nmi_disable(nmi_disable), .uip(uip),
    .upd_commit(upd_commit)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic set_idx(input logic [7:0] d);
    bus_wr(8'h70, d);
  endtask

  task automatic put(input logic [7:0] d);
    bus_wr(8'h71, d);
  endtask

  task automatic get_chk(input string req, input logic [7:0] exp);
    io_addr = 8'h71; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    chk({req, " rvalid"}, int'(io_rvalid), 1);
    chk(req, int'(io_rdata), int'(exp));
    @(negedge clk);
    chk({req, " rvalid one beat"}, int'(io_rvalid), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_req();
    upd_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R3 nmi after reset", int'(nmi_disable), 0);
    chk("R3 uip after reset", int'(uip), 0);
    chk("R3 rvalid after reset", int'(io_rvalid), 0);
    put(8'h6B);
    set_idx(8'h00);
    get_chk("R3 index 0 after reset", 8'h6B);
  endtask

  task automatic t_rw();
    set_idx(8'h20); put(8'hA5);
    set_idx(8'h21); put(8'h3C);
    set_idx(8'h7F); put(8'h01);
    set_idx(8'h20); get_chk("R5 loc 20h", 8'hA5);
    set_idx(8'h21); get_chk("R1 loc 21h", 8'h3C);
    set_idx(8'h7F); get_chk("R4 loc 7Fh", 8'h01);
  endtask

  task automatic t_nmi();
    set_idx(8'hC0);
    chk("R2 nmi set", int'(nmi_disable), 1);
    put(8'h11);
    chk("R2 nmi held on data write", int'(nmi_disable), 1);
    set_idx(8'h40);
    chk("R2 nmi cleared", int'(nmi_disable), 0);
    get_chk("R1 bit7 not part of index", 8'h11);
  endtask

  task automatic t_stat_d();
    set_idx(8'h0C); put(8'h12);
    set_idx(8'h0E); put(8'h34);
    set_idx(8'h8D); put(8'h33);
    get_chk("R6 status D value", 8'h80);
    set_idx(8'h0C); get_chk("R6 loc 0Ch untouched", 8'h12);
    set_idx(8'h0E); get_chk("R6 loc 0Eh untouched", 8'h34);
  endtask

  task automatic t_stat_a();
    set_idx(8'h0A); put(8'hFF);
    get_chk("R7 status A idle", 8'h7F);
    pulse_req();
    get_chk("R7 status A busy", 8'hFF);
    repeat (UIPN) @(negedge clk);
  endtask

  task automatic t_update();
    int n;
    set_idx(8'h00); put(8'h10);
    pulse_req();
    n = 0;
    for (int i = 0; i < UIPN + 4; i++) begin
      if (uip) n++;
      if (i == 2) upd_req = 1'b1;
      @(negedge clk);
      upd_req = 1'b0;
    end
    chk("R8 window length, repeat ignored", n, UIPN);
    chk("R9 commit low after window", int'(upd_commit), 0);
    get_chk("R9 tick advanced", 8'h11);
    put(8'hFF);
    pulse_req();
    repeat (UIPN) @(negedge clk);
    get_chk("R9 tick wraps", 8'h00);
  endtask

  task automatic t_collide();
    set_idx(8'h00); put(8'h20);
    pulse_req();
    repeat (UIPN - 1) @(negedge clk);
    chk("R9 commit in last cycle", int'(upd_commit), 1);
    put(8'h55);
    chk("R10 window closed", int'(uip), 0);
    get_chk("R10 bus write wins", 8'h55);
  endtask

  task automatic t_stray();
    set_idx(8'h30); put(8'h77);
    bus_wr(8'h72, 8'hEE);
    bus_wr(8'h60, 8'h85);
    chk("R11 nmi unchanged", int'(nmi_disable), 0);
    get_chk("R11 index and data unchanged", 8'h77);
  endtask

  task automatic t_battery();
    set_idx(8'h31); put(8'h5A);
    do_reset();
    chk("R3 nmi reset", int'(nmi_disable), 0);
    set_idx(8'h31);
    get_chk("R3 RAM kept over reset", 8'h5A);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_rw();
    t_nmi();
    t_stat_d();
    t_stat_a();
    t_update();
    t_collide();
    t_stray();
    t_battery();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule